// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a multi-bank SDRAM refreshed without a processor's help. An interval timer runs on wall-clock cycles, whatever the traffic does, and each time it wraps, one more refresh becomes owed. The scheduler takes the command bus from the command generator through a request/grant handshake. It closes any open rows with a precharge-all, waits until the bank tracker reports every bank idle, and then issues one all-bank refresh. It keeps the bus for the whole refresh recovery time, so that nothing else is issued while the device is busy.

Refresh is placed opportunistically. While the front end reports queued requests, owed refreshes are deferred, up to a bounded backlog. When the backlog is full, the scheduler asks for the bus regardless of traffic. Interval, recovery time and backlog depth are parameters in clock cycles and counts. The defaults suit a 200 MHz command clock: 1560 cycles between refreshes, 15 cycles of recovery and a backlog of 8.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bus_req` and `busy` are 0 and `cmd` is NOP.
- R2: The interval counter starts at zero when reset is released and wraps every `INTERVAL_CYC` cycles, traffic notwithstanding. Each wrap adds one owed refresh. With `traffic_pending` low, `bus_req` first rises `INTERVAL_CYC+1` cycles after the first cycle out of reset.
- R3: The owed count never exceeds `MAX_OWED`, and a wrap at the limit is lost. After a long starvation, exactly `MAX_OWED` refreshes are issued once the bus is released.
- R4: When at least one refresh is owed and `traffic_pending` is low, `bus_req` rises on the next cycle. It stays high until the hold after the refresh ends.
- R5: While `traffic_pending` is high, `bus_req` stays low until the owed count reaches `MAX_OWED`. It rises on the next cycle after that.
- R6: On the first owned cycle, if `banks_idle` is low, `cmd` carries precharge-all once and then NOP until `banks_idle` is seen high. A refresh follows on the next cycle. If `banks_idle` is high on an owned decision cycle, the refresh goes out there directly.
- R7: The refresh cycle is followed by `TRFC_CYC-1` further cycles with `busy` high and `cmd` NOP. After them, `busy` and `bus_req` fall.
- R8: `busy` rises on the cycle after `bus_grant` is sampled high while `bus_req` is high, and never without such a grant.
- R9: `cmd` encodes NOP as 0, precharge-all as 1 and refresh as 2. It is NOP on every cycle on which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| traffic_pending | input | 1 | Front end has requests queued |
| banks_idle | input | 1 | Every bank is in the precharged state |
| bus_grant | input | 1 | Command generator hands over the command bus |
| bus_req | output | 1 | Scheduler asks for the command bus |
| busy | output | 1 | Scheduler owns the bus; others must stay off it |
| cmd | output | 2 | Command driven while owning the bus (0 NOP, 1 precharge-all, 2 refresh) |

## Verification
The bench starves the scheduler under continuous traffic with no grant, so the backlog must clip at its limit. If the count wrapped or kept growing, the drain phase would issue the wrong number of refreshes. It measures exactly when a request is raised, both after reset with an idle front end and under constant traffic. A scheduler that ignored traffic, or that deferred past the limit, would miss those cycle counts. It also mixes open rows with delayed grants, which catches a refresh issued before the banks are idle, a repeated precharge-all, and a hold window one cycle short or long.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REF  = 2'd2
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_OWN,
        ST_DRAIN,
        ST_HOLD
    } sched_state_e;

    // one-cycle update pulses for the refresh backlog
    typedef struct packed {
        logic inc;
        logic dec;
    } debt_upd_t;

    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = refsched_pkg::bits_for(INTERVAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
    parameter int MAX_OWED = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  refsched_pkg::debt_upd_t upd,
    output logic                    owed_nz,
    output logic                    owed_full
);
    localparam int DW = refsched_pkg::bits_for(MAX_OWED + 1);
    localparam logic [DW-1:0] FULL = DW'(MAX_OWED);

    logic [DW-1:0] owed;
    logic inc_ok, dec_ok;

    assign inc_ok = upd.inc && (owed != FULL);
    assign dec_ok = upd.dec && (owed != '0);

    always_ff @(posedge clk) begin
        if (rst)
            owed <= '0;
        else begin
            case ({inc_ok, dec_ok})
                2'b10:   owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign owed_nz   = (owed != '0);
    assign owed_full = (owed == FULL);

    assert_owed_cap_R3: assert property (@(posedge clk) disable iff (rst)
        owed <= FULL);

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        upd.dec |-> owed != '0);

    assert_sat_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (owed == FULL && upd.inc && !upd.dec) |=> owed == FULL);

endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm #(
    parameter int TRFC_CYC = 15   // must be at least 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     owed_nz,
    input  logic                     owed_full,
    input  logic                     traffic_pending,
    input  logic                     banks_idle,
    input  logic                     bus_grant,
    output logic                     bus_req,
    output logic                     busy,
    output refsched_pkg::sdram_cmd_e cmd_o,
    output logic                     ref_issued
);
    import refsched_pkg::*;

    localparam int HW = bits_for(TRFC_CYC);
    localparam logic [HW-1:0] HOLD_LAST = HW'(TRFC_CYC - 2);

    sched_state_e st, nxt;
    logic [HW-1:0] hold_cnt;

    always_comb begin
        nxt        = st;
        cmd_o      = CMD_NOP;
        ref_issued = 1'b0;
        unique case (st)
            ST_IDLE:  if (owed_nz && (!traffic_pending || owed_full)) nxt = ST_ASK;
            ST_ASK:   if (bus_grant) nxt = ST_OWN;
            ST_OWN: begin
                if (banks_idle) begin
                    cmd_o      = CMD_REF;
                    ref_issued = 1'b1;
                    nxt        = ST_HOLD;
                end else begin
                    cmd_o = CMD_PREA;
                    nxt   = ST_DRAIN;
                end
            end
            ST_DRAIN: if (banks_idle) nxt = ST_OWN;
            ST_HOLD:  if (hold_cnt == HOLD_LAST) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            hold_cnt <= '0;
        end else begin
            st       <= nxt;
            hold_cnt <= (st == ST_HOLD) ? hold_cnt + 1'b1 : '0;
        end
    end

    assign bus_req = (st != ST_IDLE);
    assign busy    = (st == ST_OWN) || (st == ST_DRAIN) || (st == ST_HOLD);

    assert_nop_when_free_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cmd_o == CMD_NOP);

    assert_ref_banks_idle_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_REF |-> banks_idle);

    assert_ref_has_debt_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_REF |-> owed_nz);

    assert_hold_after_ref_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_REF |=> busy && cmd_o == CMD_NOP);

    assert_busy_implies_req_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> bus_req);

    assert_defer_under_traffic_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(!traffic_pending || owed_full));

    assert_busy_needs_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_grant && bus_req));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
    parameter int INTERVAL_CYC = 1560,
    parameter int TRFC_CYC     = 15,
    parameter int MAX_OWED     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       traffic_pending,
    input  logic       banks_idle,
    input  logic       bus_grant,
    output logic       bus_req,
    output logic       busy,
    output logic [1:0] cmd
);
    import refsched_pkg::*;

    logic       tick;
    logic       ref_issued;
    logic       owed_nz, owed_full;
    debt_upd_t  upd;
    sdram_cmd_e fsm_cmd;

    refsched_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    assign upd = '{inc: tick, dec: ref_issued};

    refsched_debt #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .owed_nz  (owed_nz),
        .owed_full(owed_full)
    );

    refsched_fsm #(.TRFC_CYC(TRFC_CYC)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .owed_nz        (owed_nz),
        .owed_full      (owed_full),
        .traffic_pending(traffic_pending),
        .banks_idle     (banks_idle),
        .bus_grant      (bus_grant),
        .bus_req        (bus_req),
        .busy           (busy),
        .cmd_o          (fsm_cmd),
        .ref_issued     (ref_issued)
    );

    assign cmd = fsm_cmd;

endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
    localparam int IV = 100;
    localparam int TR = 5;
    localparam int MX = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic traffic_pending = 1'b0;
    logic banks_idle = 1'b1;
    logic bus_grant = 1'b0;
    logic bus_req, busy;
    logic [1:0] cmd;

    always #4 clk = ~clk;

    sdram_refresh_sched #(.INTERVAL_CYC(IV), .TRFC_CYC(TR), .MAX_OWED(MX)) u_dut (
        .clk(clk), .rst(rst), .traffic_pending(traffic_pending),
        .banks_idle(banks_idle), .bus_grant(bus_grant),
        .bus_req(bus_req), .busy(busy), .cmd(cmd)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference: phase 0 idle, 1 asking, 2 decide, 3 draining, 4 holding
    int m_timer = 0, m_owed = 0, m_ph = 0, m_hold = 0;
    int mode = 0;
    logic [31:0] lfsr = 32'h1ACE_5EED;
    bit rows_open = 0;
    int pre_cnt = 0;
    bit seen_req = 0;
    int seen_cmd = 0;

    function automatic bit rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[0];
    endfunction

    function automatic int exp_cmd();
        if (m_ph == 2) return banks_idle ? 2 : 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic one_cycle();
        bit r1, r2, r3, g;
        int ec, ereq, ebusy;
        r1 = rnd(); r2 = rnd(); r3 = rnd();
        if (m_ph >= 2) begin
            if (pre_cnt > 0) begin
                pre_cnt--;
                if (pre_cnt == 0) rows_open = 0;
            end
        end else begin
            case (mode)
                4:       rows_open = 1;
                5:       rows_open = 0;
                default: rows_open = r1;
            endcase
        end
        banks_idle = !rows_open;
        case (mode)
            1, 5:    traffic_pending = 0;
            3:       traffic_pending = r2;
            default: traffic_pending = 1;
        endcase
        case (mode)
            1, 5, 6: g = 1;
            4:       g = 0;
            default: g = r3;
        endcase
        bus_grant = (m_ph == 1) && g;
        #1;
        ec    = rst ? 0 : exp_cmd();
        ereq  = (!rst && m_ph != 0) ? 1 : 0;
        ebusy = (!rst && m_ph >= 2) ? 1 : 0;
        if (rst) begin
            chk(bus_req === 1'b0, "R1 bus_req", int'(bus_req), 0);
            chk(busy === 1'b0, "R1 busy", int'(busy), 0);
            chk(cmd === 2'd0, "R1 cmd", int'(cmd), 0);
        end else begin
            chk(bus_req === ereq[0], "R4 bus_req", int'(bus_req), ereq);
            chk(busy === ebusy[0], "R8 busy", int'(busy), ebusy);
            if (ebusy == 0)
                chk(cmd === 2'd0, "R9 cmd while free", int'(cmd), 0);
            else
                chk(cmd === 2'(ec), "R6,R7 cmd while owned", int'(cmd), ec);
        end
        seen_req = bus_req;
        seen_cmd = int'(cmd);
        @(posedge clk);
        if (rst) begin
            m_timer = 0; m_owed = 0; m_ph = 0; m_hold = 0; pre_cnt = 0;
        end else begin
            bit tick, dec;
            tick = (m_timer == IV - 1);
            dec  = (m_ph == 2) && banks_idle;
            if (ec == 1) pre_cnt = 3;
            case (m_ph)
                0: if (m_owed > 0 && (!traffic_pending || m_owed == MX)) m_ph = 1;
                1: if (bus_grant) m_ph = 2;
                2: begin
                    if (banks_idle) begin m_ph = 4; m_hold = 0; end
                    else m_ph = 3;
                end
                3: if (banks_idle) m_ph = 2;
                default: begin
                    if (m_hold == TR - 2) m_ph = 0;
                    else m_hold++;
                end
            endcase
            if (tick && m_owed < MX) m_owed++;
            if (dec) m_owed--;
            m_timer = tick ? 0 : m_timer + 1;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        int first, refs, t0, expn;
        @(negedge clk);
        rst = 1; mode = 1;
        repeat (4) one_cycle();
        rst = 0;

        // R2: first request after reset with an idle front end
        first = -1;
        for (int i = 0; i < 800; i++) begin
            one_cycle();
            if (first < 0 && seen_req) first = i;
        end
        chk(first == IV + 1, "R2 first request cycle", first, IV + 1);

        mode = 2;
        for (int i = 0; i < 1200; i++) one_cycle();
        mode = 3;
        for (int i = 0; i < 1000; i++) one_cycle();

        // R3: starve, then drain exactly the capped backlog
        mode = 4;
        for (int i = 0; i < 7 * IV; i++) one_cycle();
        while (m_timer != 0) one_cycle();
        mode = 5;
        refs = 0;
        for (int i = 0; i < 60; i++) begin
            one_cycle();
            if (seen_cmd == 2) refs++;
        end
        chk(refs == MX, "R3 refreshes after saturation", refs, MX);

        // R5: deferral under traffic until the backlog is full
        while (!(m_timer == IV / 2 && m_ph == 0 && m_owed == 0)) one_cycle();
        t0 = m_timer;
        expn = (IV - 1 - t0) + IV * (MX - 1) + 2;
        mode = 6;
        first = -1;
        for (int i = 0; i < 2000 && first < 0; i++) begin
            one_cycle();
            if (seen_req) first = i;
        end
        chk(first == expn, "R5 forced request cycle", first, expn);
        for (int i = 0; i < 400; i++) one_cycle();

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule